// File: doc/BRIEF.md
# DMA Request Edge Capture Latch

This block turns external DMA request inputs into held pending-request flags for a DMA controller that runs in edge-sense mode. It provides several identical channels. Each channel takes one asynchronous request input, a 2-bit trigger-mode field, and an acknowledge input from the transfer engine. The request input is synchronized to the bus clock. The chosen transition, rising or falling, is then detected by comparing the newest synchronized sample with the one before it.

A detected edge sets a sticky pending bit, and later changes of the input level do not affect it. The pending bit holds a single request. Edges that arrive while it is set are dropped. The bit clears when the controller drives the acknowledge for that channel, and the next valid edge after that sets it again. The two trigger-mode codes that do not select an edge keep the bit at zero. A small read port returns the pending bit of one selected channel.

Top module: `dreq_edge_capture`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, every pending bit is 0 after that edge.
- R2: In mode 2'b10 (rising), a 0-to-1 change on a channel's request input sets its pending bit. The bit is still 0 after the second rising clock edge following the change and is 1 after the third.
- R3: In mode 2'b00 (falling), a 1-to-0 change on the request input sets the pending bit with the same three-edge latency.
- R4: A transition of the polarity that the mode does not select leaves the pending bit at 0.
- R5: Once set, the pending bit stays 1 while no acknowledge arrives, whatever the request input does.
- R6: An acknowledge high at a clock edge leaves the channel's pending bit at 0 after that edge.
- R7: Valid edges that arrive while the pending bit is 1 are discarded. After the acknowledge clears the bit it stays 0 until a new edge arrives.
- R8: A valid edge that arrives after the bit has been cleared sets it again.
- R9: When the acknowledge and the setting edge land on the same clock edge, the acknowledge wins. The bit stays 0 and the edge is lost.
- R10: Mode codes 2'b01 and 2'b11 disable capture. The pending bit is 0 after any edge at which the mode is one of these codes, and this also clears a bit that was set.
- R11: Channels are independent. An edge or acknowledge on one channel does not change another channel's pending bit.
- R12: `stat_bit` always equals the pending bit of the channel selected by `stat_sel`.
- R13: A request input level present when reset is released is not taken as an edge. Only a transition seen after the synchronizer history has refilled can set a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_mode | input | 2*NUM_CH | Per-channel trigger mode, channel c in bits [2c+1:2c] |
| req_in | input | NUM_CH | Asynchronous request inputs, one per channel |
| ack_in | input | NUM_CH | Acknowledge from the transfer engine, one per channel |
| pend_o | output | NUM_CH | Pending-request flags |
| stat_sel | input | $clog2(NUM_CH) | Channel index for the status read |
| stat_bit | output | 1 | Pending flag of the selected channel |

## Verification
Several properties are checked on every cycle for every channel: that an acknowledge always clears the flag, that a disabled mode always forces it to zero, that a set flag survives any cycle without an acknowledge, that a clear flag cannot rise on a cycle carrying an acknowledge, and that the status port follows the selected flag. The bench scenarios are needed for the behaviours that depend on the request history. These are the exact three-edge latency, rejection of the wrong polarity, dropping of edges that arrive while the flag is set, re-arming after a clear, the race between acknowledge and edge, and the absence of a false edge when reset is released with the input high.

// File: rtl/dreq_edge_pkg.sv
package dreq_edge_pkg;

    // Trigger-mode codes; only the two even codes capture edges
    typedef enum logic [1:0] {
        TRG_FALL  = 2'b00,
        TRG_OFF_A = 2'b01,
        TRG_RISE  = 2'b10,
        TRG_OFF_B = 2'b11
    } trig_mode_e;

    localparam int SYNC_STAGES = 2;
    localparam int HIST_DEPTH  = SYNC_STAGES + 1;

    // Synchronizer and history state of one channel
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [HIST_DEPTH-1:0]  vld;
    } chan_hist_t;

    // Samples handed to the edge selector
    typedef struct packed {
        logic cur;
        logic prev;
        logic ok;
    } samp_pair_t;

    function automatic logic mode_captures(input logic [1:0] m);
        return (m == TRG_FALL) || (m == TRG_RISE);
    endfunction

    function automatic logic edge_hit(input logic [1:0] m, input samp_pair_t s);
        logic hit;
        hit = 1'b0;
        if (s.ok) begin
            case (m)
                TRG_RISE: hit = s.cur & ~s.prev;
                TRG_FALL: hit = ~s.cur & s.prev;
                default:  hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/dreq_in_sync.sv
module dreq_in_sync
    import dreq_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_raw,
    output samp_pair_t samp
);

    chan_hist_t hist_q;
    chan_hist_t hist_d;

    always_comb begin
        hist_d      = hist_q;
        hist_d.sync = {hist_q.sync[SYNC_STAGES-2:0], req_raw};
        hist_d.prev = hist_q.sync[SYNC_STAGES-1];
        hist_d.vld  = {hist_q.vld[HIST_DEPTH-2:0], 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    // The pair is usable only once the older sample came from a real input
    assign samp.cur  = hist_q.sync[SYNC_STAGES-1];
    assign samp.prev = hist_q.prev;
    assign samp.ok   = hist_q.vld[HIST_DEPTH-1];

endmodule

// File: rtl/dreq_pend_bit.sv
module dreq_pend_bit
    import dreq_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  samp_pair_t samp,
    input  logic       ack,
    output logic       pend
);

    logic pend_q;
    logic pend_d;
    logic hit;

    assign hit = edge_hit(mode, samp);

    // Priority: reset, disabled mode, acknowledge, new edge, hold
    always_comb begin
        if (!mode_captures(mode)) begin
            pend_d = 1'b0;
        end else if (ack) begin
            pend_d = 1'b0;
        end else if (hit) begin
            pend_d = 1'b1;
        end else begin
            pend_d = pend_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/dreq_edge_capture.sv
module dreq_edge_capture
    import dreq_edge_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*NUM_CH-1:0] trig_mode,
    input  logic [NUM_CH-1:0]   req_in,
    input  logic [NUM_CH-1:0]   ack_in,
    output logic [NUM_CH-1:0]   pend_o,
    input  logic [SEL_W-1:0]    stat_sel,
    output logic                stat_bit
);

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            samp_pair_t samp;

            dreq_in_sync u_sync (
                .clk     (clk),
                .rst     (rst),
                .req_raw (req_in[c]),
                .samp    (samp)
            );

            dreq_pend_bit u_pend (
                .clk  (clk),
                .rst  (rst),
                .mode (trig_mode[2*c +: 2]),
                .samp (samp),
                .ack  (ack_in[c]),
                .pend (pend_o[c])
            );
        end
    endgenerate

    always_comb begin
        stat_bit = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (stat_sel == SEL_W'(i)) begin
                stat_bit = pend_o[i];
            end
        end
    end

endmodule

// File: rtl/dreq_edge_capture_chk.sv
module dreq_edge_capture_chk #(
    parameter int NUM_CH = 4,
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic [2*NUM_CH-1:0] trig_mode,
    input logic [NUM_CH-1:0]   req_in,
    input logic [NUM_CH-1:0]   ack_in,
    input logic [NUM_CH-1:0]   pend_o,
    input logic [SEL_W-1:0]    stat_sel,
    input logic                stat_bit
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pend_o == '0));

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chk
            assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
                ack_in[c] |=> !pend_o[c]);

            assert_disabled_zero_R10: assert property (@(posedge clk) disable iff (rst)
                trig_mode[2*c] |=> !pend_o[c]);

            assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
                (pend_o[c] && !ack_in[c] && !trig_mode[2*c]) |=> pend_o[c]);

            assert_ack_beats_edge_R9: assert property (@(posedge clk) disable iff (rst)
                (!pend_o[c] && ack_in[c]) |=> !pend_o[c]);
        end
    endgenerate

    always_comb begin
        if (!rst && int'(stat_sel) < NUM_CH) begin
            assert_stat_port_R12: assert (stat_bit == pend_o[stat_sel]);
        end
    end

endmodule

bind dreq_edge_capture dreq_edge_capture_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig_mode (trig_mode),
    .req_in    (req_in),
    .ack_in    (ack_in),
    .pend_o    (pend_o),
    .stat_sel  (stat_sel),
    .stat_bit  (stat_bit)
);

// File: tb/dreq_edge_capture_bench.sv
`timescale 1ns/1ps
module dreq_edge_capture_bench;

    localparam int NUM_CH = 4;
    localparam int SEL_W  = 2;

    logic                clk = 1'b0;
    logic                rst;
    logic [2*NUM_CH-1:0] trig_mode;
    logic [NUM_CH-1:0]   req_in;
    logic [NUM_CH-1:0]   ack_in;
    logic [NUM_CH-1:0]   pend_o;
    logic [SEL_W-1:0]    stat_sel;
    logic                stat_bit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    dreq_edge_capture #(.NUM_CH(NUM_CH)) u_dreq_edge_capture (
        .clk       (clk),
        .rst       (rst),
        .trig_mode (trig_mode),
        .req_in    (req_in),
        .ack_in    (ack_in),
        .pend_o    (pend_o),
        .stat_sel  (stat_sel),
        .stat_bit  (stat_bit)
    );

    // Row fields: {mode[1:0], request level, ack pulse, expected pending} for channel 0
    localparam int NROW = 17;
    localparam logic [4:0] VEC [NROW] = '{
        5'b10_0_0_0, // R4 idle low in rising mode
        5'b10_1_0_1, // R2 rising edge sets
        5'b10_0_0_1, // R5 falling level does not clear
        5'b10_1_0_1, // R7 edge while set
        5'b10_1_1_0, // R6 ack clears, R7 dropped edge not kept
        5'b10_0_0_0, // R4 falling ignored in rising mode
        5'b10_1_0_1, // R8 re-arm after clear
        5'b00_1_1_0, // R6 ack clears, switch to falling
        5'b00_0_0_1, // R3 falling edge sets
        5'b00_0_1_0, // R6 ack clears
        5'b01_1_0_0, // R10 disabled code 01
        5'b01_0_0_0, // R10 disabled code 01
        5'b11_1_0_0, // R10 disabled code 11
        5'b10_1_0_0, // R4 no transition, level high
        5'b10_0_0_0, // R4 falling ignored
        5'b10_1_0_1, // R8 rising sets again
        5'b11_1_0_0  // R10 disabling clears a set bit
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst       = 1'b1;
        trig_mode = {4{2'b01}};
        req_in    = '0;
        ack_in    = '0;
        stat_sel  = '0;
        repeat (3) @(negedge clk);
        check("R1 reset state", 32'(pend_o), 32'h0);
        rst = 1'b0;
        trig_mode[1:0] = 2'b10;
        repeat (5) @(negedge clk);

        // Vector walk on channel 0
        for (int i = 0; i < NROW; i++) begin
            trig_mode[1:0] = VEC[i][4:3];
            req_in[0]      = VEC[i][2];
            ack_in[0]      = VEC[i][1];
            @(negedge clk);
            ack_in[0] = 1'b0;
            repeat (3) @(negedge clk);
            check($sformatf("R2-table row %0d ch0", i), 32'(pend_o[0]), 32'(VEC[i][0]));
        end

        // R2 latency: 0 after two edges, 1 after three
        trig_mode = {4{2'b10}};
        req_in    = '0;
        repeat (5) @(negedge clk);
        req_in[1] = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 not yet set after two edges", 32'(pend_o[1]), 32'h0);
        @(negedge clk);
        check("R2 set after third edge", 32'(pend_o[1]), 32'h1);
        ack_in[1] = 1'b1;
        @(negedge clk);
        ack_in[1] = 1'b0;
        check("R6 ack clears ch1", 32'(pend_o[1]), 32'h0);

        // R11 independence
        req_in[2] = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 only ch2 pending", 32'(pend_o), 32'h4);
        ack_in[1] = 1'b1;
        @(negedge clk);
        ack_in[1] = 1'b0;
        check("R11 ack on ch1 leaves ch2", 32'(pend_o), 32'h4);

        // R12 status read port
        stat_sel = 2'd2;
        #0.5;
        check("R12 stat_sel=2", 32'(stat_bit), 32'h1);
        stat_sel = 2'd0;
        #0.5;
        check("R12 stat_sel=0", 32'(stat_bit), 32'h0);
        ack_in[2] = 1'b1;
        @(negedge clk);
        ack_in[2] = 1'b0;
        stat_sel = 2'd2;
        #0.5;
        check("R12 stat_sel=2 after clear", 32'(stat_bit), 32'h0);

        // R9 acknowledge and edge on the same clock edge, channel 3
        @(negedge clk);
        req_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ack_in[3] = 1'b1;
        @(negedge clk);
        ack_in[3] = 1'b0;
        check("R9 ack wins over edge", 32'(pend_o[3]), 32'h0);
        repeat (3) @(negedge clk);
        check("R9 edge is lost", 32'(pend_o[3]), 32'h0);

        // R1 and R13: reset with inputs high, then release
        rst    = 1'b1;
        req_in = '1;
        repeat (3) @(negedge clk);
        check("R1 reset clears all", 32'(pend_o), 32'h0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check("R13 no false edge after reset", 32'(pend_o), 32'h0);
        req_in[0] = 1'b0;
        repeat (2) @(negedge clk);
        req_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        check("R13 real edge after warm-up", 32'(pend_o), 32'h1);

        finish_run();
    end

endmodule